// File: doc/BRIEF.md
# Biphase-Mark Audio Serializer with Channel Status

This block turns a stream of stereo audio pairs into a single-wire consumer digital audio line. Each frame carries two 32-slot subframes, one per channel. Each subframe holds a 4-slot sync preamble, a 24-bit sample, a validity flag (V), a user bit (U), a channel-status bit (C) and an even-parity bit. Every slot after the preamble is sent as a biphase-mark cell of two half-cells. The block is clocked at one half-cell per cycle, so one frame takes 128 cycles and the clock runs at 128 times the sample rate.

Samples arrive as pairs through a ready/valid handshake. A pair is held in a one-deep pending slot and moves into the frame being sent at the next frame boundary. If no pair is waiting when a frame starts, that frame carries silence flagged invalid. Channel status comes from two 192-bit banks, one per channel, each written as six 32-bit words. Bit n of a bank is sent in frame n of every 192-frame block. Three select inputs are active-low. When a select is cleared, V, U or C is taken from a manual source: a set bit for V and U, the bank for C. When a select is set, the bit is taken from the flags that come with each pair. Holding V at 1 through the manual path is the way to mute.

A two-state machine (`ST_OFF`, `ST_RUN`) sequences the block. Transition *go* (`ST_OFF` to `ST_RUN`) is taken when `enable` is high and the output-path reset `rst_out_n` is released. Transition *stop* (`ST_RUN` to `ST_OFF`) is taken when either of those drops. A separate input-path reset `rst_in_n` clears the pending slot and refuses new pairs. The intended bring-up order is: both resets low, release `rst_out_n`, release `rst_in_n`, then raise `enable`.

Top module: `spdif_tx`

## Requirements
- R1: While the machine is in `ST_OFF` (`enable` low or `rst_out_n` low), `line_out` is held at 0. Clearing `enable` stops transmission within two cycles.
- R2: In every slot from 4 to 31, the line level changes at the start of the cell. It changes again half-way through the cell exactly when the slot's bit is 1.
- R3: Slots 0–3 are sent as 8 half-cells, first half-cell first. B is 11101000, M is 11100010 and W is 11100100, written for a preceding line level of 0. All 8 half-cells are inverted when the preceding level is 1. Channel A uses B in frame 0 of a block and M in every other frame. Channel B always uses W.
- R4: The frame counter runs 0 to 191 and wraps. The first frame after *go* is frame 0, and B appears every 192 frames.
- R5: Slots 4–27 carry the 24-bit sample. Channel A is in the first subframe and channel B in the second. With `msb_first`=0, sample bit 0 is in slot 4. With `msb_first`=1, sample bit 23 is in slot 4.
- R6: Slot 28 (V) equals `v_set` when `v_sel`=0, and equals the pair's `s_v` when `v_sel`=1.
- R7: Slot 29 (U) equals `u_set` when `u_sel`=0, and equals the pair's `s_u` when `u_sel`=1.
- R8: Slot 30 (C) equals bank bit f of the subframe's channel when `c_sel`=0, where f is the frame number and the bit is word f/32, bit f%32. When `c_sel`=1, slot 30 equals the pair's `s_c`.
- R9: Slot 31 makes the count of ones in slots 4–31 even.
- R10: `s_ready` is high exactly when `rst_in_n` is high and no pair is pending. A pair accepted during frame n, or before *go* for frame 0, is sent in frame n+1.
- R11: A frame that starts with no pending pair carries zero audio with V=1, whatever the V controls say, and with stream U and C taken as 0.
- R12: With `rst_in_n` low, `s_ready` is 0 and any pending pair is discarded, so the frames that follow are treated as in R11.
- R13: A cycle with `cs_we` high writes `cs_wdata` into word `cs_idx` (0–5) of bank `cs_side` (0 = channel A, 1 = channel B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, 128 × sample rate |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| enable | input | 1 | Transmission enable |
| rst_out_n | input | 1 | Active-low reset of the serializer path |
| rst_in_n | input | 1 | Active-low reset of the sample input path |
| msb_first | input | 1 | 1 puts the sample MSB in slot 4 |
| v_sel | input | 1 | 0 selects manual V, 1 selects the stream flag |
| v_set | input | 1 | Manual V value (1 mutes) |
| u_sel | input | 1 | 0 selects manual U, 1 selects the stream flag |
| u_set | input | 1 | Manual U value |
| c_sel | input | 1 | 0 takes C from the banks, 1 from the stream flag |
| cs_we | input | 1 | Channel-status word write strobe |
| cs_side | input | 1 | Bank to write, 0 = A, 1 = B |
| cs_idx | input | 3 | Word index within the bank, 0 to 5 |
| cs_wdata | input | 32 | Word to write |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Pending slot can take a pair |
| s_a | input | 24 | Channel A sample |
| s_b | input | 24 | Channel B sample |
| s_v | input | 1 | Stream validity flag for the pair |
| s_u | input | 1 | Stream user bit for the pair |
| s_c | input | 1 | Stream channel-status bit for the pair |
| line_out | output | 1 | Biphase-mark coded line |

## Verification
The line is recorded and decoded back into slots. Four configurations are each run from a fresh start. The first sends over 192 frames with distinct per-sample audio, manual V=0, manual U=1 and bank-driven C. This separates the B and M preambles at the block wrap and exposes any swap of the bank sides or misplacement of bank bits. The second uses mute, stream U and C, and MSB-first ordering, which tells the bit order and the select polarities apart. The third uses stream V. The fourth holds the input path in reset after preloading a pair, which separates a discarded pair from a sent one. Every subframe is also checked for cell-boundary transitions, polarity-correct preambles, parity and the one-frame pipeline delay; frame 0 being silent pins that delay.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
    localparam int SF_SLOTS     = 32;
    localparam int HC_PER_FRAME = 2 * 2 * SF_SLOTS;
    localparam int PRE_SLOTS    = 4;
    localparam int AUD_LO       = 4;
    localparam int V_SLOT       = 28;
    localparam int U_SLOT       = 29;
    localparam int C_SLOT       = 30;
    localparam int P_SLOT       = 31;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tx_state_e;

    // Sync patterns, first half-cell in the MSB, for a preceding level of 0
    localparam logic [7:0] PRE_B = 8'b1110_1000;
    localparam logic [7:0] PRE_M = 8'b1110_0010;
    localparam logic [7:0] PRE_W = 8'b1110_0100;
endpackage

// File: rtl/spdif_tx_csbank.sv
module spdif_tx_csbank #(
    parameter int CS_BITS   = 192,
    parameter int WORD_W    = 32,
    localparam int CS_WORDS = CS_BITS / WORD_W,
    localparam int IDX_W    = $clog2(CS_WORDS),
    localparam int FRM_W    = $clog2(CS_BITS),
    localparam int WSEL_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              side,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_side,
    input  logic [FRM_W-1:0]  rd_bit,
    output logic              rd_val
);
    logic [WORD_W-1:0] word_q [2][CS_WORDS];
    logic              idx_ok;

    assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(CS_WORDS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                for (int w = 0; w < CS_WORDS; w++) begin
                    word_q[s][w] <= '0;
                end
            end
        end else if (we && idx_ok) begin
            word_q[side][idx] <= wdata;
        end
    end

    logic [FRM_W-WSEL_W-1:0] rd_word;
    logic [WSEL_W-1:0]       rd_pos;
    assign rd_word = rd_bit[FRM_W-1:WSEL_W];
    assign rd_pos  = rd_bit[WSEL_W-1:0];
    assign rd_val  = word_q[rd_side][IDX_W'(rd_word)][rd_pos];
endmodule

// File: rtl/spdif_tx_ctrl.sv
module spdif_tx_ctrl
    import spdif_tx_pkg::*;
#(
    parameter int AUD_W   = 24,
    parameter int CS_BITS = 192,
    localparam int FRM_W  = $clog2(CS_BITS),
    localparam int HC_W   = $clog2(HC_PER_FRAME)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rst_out_n,
    input  logic             rst_in_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [AUD_W-1:0] s_a,
    input  logic [AUD_W-1:0] s_b,
    input  logic             s_v,
    input  logic             s_u,
    input  logic             s_c,
    output logic             run,
    output logic [HC_W-1:0]  hc,
    output logic [FRM_W-1:0] frm,
    output logic [AUD_W-1:0] cur_a,
    output logic [AUD_W-1:0] cur_b,
    output logic             cur_v,
    output logic             cur_u,
    output logic             cur_c,
    output logic             cur_miss
);
    tx_state_e        state_q, state_d;
    logic [HC_W-1:0]  hc_q;
    logic [FRM_W-1:0] frm_q;
    logic             frame_end;
    logic             fire;

    logic             nxt_full;
    logic [AUD_W-1:0] nxt_a, nxt_b;
    logic             nxt_v, nxt_u, nxt_c;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions: go and stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enable && rst_out_n)    state_d = ST_RUN;
            ST_RUN:  if (!enable || !rst_out_n)  state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        run       = (state_q == ST_RUN);
        frame_end = run && (hc_q == HC_W'(HC_PER_FRAME - 1));
        s_ready   = rst_in_n && !nxt_full;
        fire      = s_valid && s_ready;
    end

    // Half-cell and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc_q  <= '0;
            frm_q <= '0;
        end else if (!run) begin
            hc_q  <= '0;
            frm_q <= '0;
        end else begin
            hc_q <= hc_q + 1'b1;
            if (frame_end) begin
                frm_q <= (frm_q == FRM_W'(CS_BITS - 1)) ? '0 : frm_q + 1'b1;
            end
        end
    end

    // Pending pair slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_full <= 1'b0;
            nxt_a    <= '0;
            nxt_b    <= '0;
            nxt_v    <= 1'b0;
            nxt_u    <= 1'b0;
            nxt_c    <= 1'b0;
        end else if (!rst_in_n) begin
            nxt_full <= 1'b0;
        end else if (fire) begin
            nxt_full <= 1'b1;
            nxt_a    <= s_a;
            nxt_b    <= s_b;
            nxt_v    <= s_v;
            nxt_u    <= s_u;
            nxt_c    <= s_c;
        end else if (frame_end) begin
            nxt_full <= 1'b0;
        end
    end

    // Pair on the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_a    <= '0;
            cur_b    <= '0;
            {cur_v, cur_u, cur_c} <= 3'b000;
            cur_miss <= 1'b1;
        end else if (!run) begin
            cur_a    <= '0;
            cur_b    <= '0;
            {cur_v, cur_u, cur_c} <= 3'b000;
            cur_miss <= 1'b1;
        end else if (frame_end) begin
            if (nxt_full) begin
                cur_a    <= nxt_a;
                cur_b    <= nxt_b;
                {cur_v, cur_u, cur_c} <= {nxt_v, nxt_u, nxt_c};
                cur_miss <= 1'b0;
            end else begin
                cur_a    <= '0;
                cur_b    <= '0;
                {cur_v, cur_u, cur_c} <= 3'b000;
                cur_miss <= 1'b1;
            end
        end
    end

    assign hc  = hc_q;
    assign frm = frm_q;

    a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frm_q == FRM_W'(CS_BITS - 1)) |=> (frm_q == '0));

    a_r10_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);

    a_r11_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !nxt_full) |=> cur_miss);

    a_r1_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> !run);
endmodule

// File: rtl/spdif_tx_sfbuild.sv
module spdif_tx_sfbuild
    import spdif_tx_pkg::*;
#(
    parameter int AUD_W   = 24,
    localparam int HC_W   = $clog2(HC_PER_FRAME),
    localparam int SLOT_W = $clog2(SF_SLOTS)
) (
    input  logic [HC_W-1:0]  hc,
    input  logic             frm_zero,
    input  logic [AUD_W-1:0] cur_a,
    input  logic [AUD_W-1:0] cur_b,
    input  logic             cur_v,
    input  logic             cur_u,
    input  logic             cur_c,
    input  logic             cur_miss,
    input  logic             msb_first,
    input  logic             v_sel,
    input  logic             v_set,
    input  logic             u_sel,
    input  logic             u_set,
    input  logic             c_sel,
    input  logic             cs_bit,
    output logic             is_pre,
    output logic [7:0]       pre_pat,
    output logic             data_bit
);
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] aidx;
    logic              chan;
    logic [AUD_W-1:0]  aud, aud_rev, aud_tx;
    logic              v_bit, u_bit, c_bit, par_bit;

    assign slot = hc[HC_W-2:1];
    assign chan = hc[HC_W-1];
    assign aud  = chan ? cur_b : cur_a;
    assign aidx = slot - SLOT_W'(AUD_LO);

    for (genvar gi = 0; gi < AUD_W; gi++) begin : g_rev
        assign aud_rev[gi] = aud[AUD_W-1-gi];
    end

    always_comb begin
        aud_tx  = msb_first ? aud_rev : aud;
        v_bit   = cur_miss | (v_sel ? cur_v : v_set);
        u_bit   = u_sel ? cur_u : u_set;
        c_bit   = c_sel ? cur_c : cs_bit;
        par_bit = (^aud_tx) ^ v_bit ^ u_bit ^ c_bit;

        is_pre  = (slot < SLOT_W'(PRE_SLOTS));
        if (chan)          pre_pat = PRE_W;
        else if (frm_zero) pre_pat = PRE_B;
        else               pre_pat = PRE_M;

        if (slot == SLOT_W'(V_SLOT))      data_bit = v_bit;
        else if (slot == SLOT_W'(U_SLOT)) data_bit = u_bit;
        else if (slot == SLOT_W'(C_SLOT)) data_bit = c_bit;
        else if (slot == SLOT_W'(P_SLOT)) data_bit = par_bit;
        else if (!is_pre)                 data_bit = aud_tx[aidx];
        else                              data_bit = 1'b0;
    end
endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc
    import spdif_tx_pkg::*;
#(
    localparam int HC_W = $clog2(HC_PER_FRAME)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [HC_W-1:0] hc,
    input  logic            is_pre,
    input  logic [7:0]      pre_pat,
    input  logic            data_bit,
    output logic            line_out
);
    logic       line_q, line_d;
    logic       pol_q, pol;
    logic       sub_start;
    logic [2:0] k;

    assign sub_start = (hc[HC_W-2:0] == '0);
    assign k         = hc[2:0];

    always_comb begin
        pol = sub_start ? line_q : pol_q;
        if (!run)         line_d = 1'b0;
        else if (is_pre)  line_d = pre_pat[3'd7 - k] ^ pol;
        else if (!hc[0])  line_d = ~line_q;
        else              line_d = line_q ^ data_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pol_q  <= 1'b0;
        end else begin
            line_q <= line_d;
            pol_q  <= pol;
        end
    end

    assign line_out = line_q;

    a_r2_cell_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !is_pre && !hc[0]) |=> (line_q != $past(line_q)));

    a_r1_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> !line_q);
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
    import spdif_tx_pkg::*;
#(
    parameter int AUD_W     = 24,
    parameter int CS_BITS   = 192,
    parameter int CS_WORD_W = 32,
    localparam int CS_IDX_W = $clog2(CS_BITS / CS_WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 rst_out_n,
    input  logic                 rst_in_n,
    input  logic                 msb_first,
    input  logic                 v_sel,
    input  logic                 v_set,
    input  logic                 u_sel,
    input  logic                 u_set,
    input  logic                 c_sel,
    input  logic                 cs_we,
    input  logic                 cs_side,
    input  logic [CS_IDX_W-1:0]  cs_idx,
    input  logic [CS_WORD_W-1:0] cs_wdata,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [AUD_W-1:0]     s_a,
    input  logic [AUD_W-1:0]     s_b,
    input  logic                 s_v,
    input  logic                 s_u,
    input  logic                 s_c,
    output logic                 line_out
);
    localparam int FRM_W = $clog2(CS_BITS);
    localparam int HC_W  = $clog2(HC_PER_FRAME);

    logic             run;
    logic [HC_W-1:0]  hc;
    logic [FRM_W-1:0] frm;
    logic [AUD_W-1:0] cur_a, cur_b;
    logic             cur_v, cur_u, cur_c, cur_miss;
    logic             cs_bit, is_pre, data_bit;
    logic [7:0]       pre_pat;

    spdif_tx_ctrl #(.AUD_W(AUD_W), .CS_BITS(CS_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rst_out_n(rst_out_n),
        .rst_in_n(rst_in_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_a(s_a), .s_b(s_b), .s_v(s_v), .s_u(s_u), .s_c(s_c),
        .run(run), .hc(hc), .frm(frm), .cur_a(cur_a), .cur_b(cur_b),
        .cur_v(cur_v), .cur_u(cur_u), .cur_c(cur_c), .cur_miss(cur_miss)
    );

    spdif_tx_csbank #(.CS_BITS(CS_BITS), .WORD_W(CS_WORD_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cs_we), .side(cs_side), .idx(cs_idx),
        .wdata(cs_wdata), .rd_side(hc[HC_W-1]), .rd_bit(frm), .rd_val(cs_bit)
    );

    spdif_tx_sfbuild #(.AUD_W(AUD_W)) u_build (
        .hc(hc), .frm_zero(frm == '0), .cur_a(cur_a), .cur_b(cur_b),
        .cur_v(cur_v), .cur_u(cur_u), .cur_c(cur_c), .cur_miss(cur_miss),
        .msb_first(msb_first), .v_sel(v_sel), .v_set(v_set), .u_sel(u_sel),
        .u_set(u_set), .c_sel(c_sel), .cs_bit(cs_bit), .is_pre(is_pre),
        .pre_pat(pre_pat), .data_bit(data_bit)
    );

    spdif_tx_bmc u_bmc (
        .clk(clk), .rst_n(rst_n), .run(run), .hc(hc), .is_pre(is_pre),
        .pre_pat(pre_pat), .data_bit(data_bit), .line_out(line_out)
    );
endmodule

// File: tb/spdif_tx_bench.sv
`timescale 1ns/1ps
module spdif_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, rst_out_n = 1'b0, rst_in_n = 1'b1;
    logic        msb_first = 1'b0, v_sel = 1'b0, v_set = 1'b0;
    logic        u_sel = 1'b0, u_set = 1'b0, c_sel = 1'b0;
    logic        cs_we = 1'b0, cs_side = 1'b0;
    logic [2:0]  cs_idx = '0;
    logic [31:0] cs_wdata = '0;
    logic        s_valid = 1'b0, s_ready;
    logic [23:0] s_a, s_b;
    logic        s_v, s_u, s_c, line_out;

    int  n_tests = 0, n_fail = 0;
    bit  done = 0;
    int  k = 0;
    logic fire_q = 1'b0, drv_clr = 1'b0;
    bit  rec [0:32767];
    int  rec_n = 0;
    logic rec_on = 1'b0, rec_clr = 1'b0;
    int  cur_ph = 0;

    always #2.5 clk = ~clk;

    spdif_tx u_spdif_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rst_out_n(rst_out_n),
        .rst_in_n(rst_in_n), .msb_first(msb_first), .v_sel(v_sel),
        .v_set(v_set), .u_sel(u_sel), .u_set(u_set), .c_sel(c_sel),
        .cs_we(cs_we), .cs_side(cs_side), .cs_idx(cs_idx), .cs_wdata(cs_wdata),
        .s_valid(s_valid), .s_ready(s_ready), .s_a(s_a), .s_b(s_b),
        .s_v(s_v), .s_u(s_u), .s_c(s_c), .line_out(line_out)
    );

    function automatic logic [23:0] smp_a(int n);
        return 24'(n * 32'h0003_A5F1 + 32'h0001_0203);
    endfunction
    function automatic logic [23:0] smp_b(int n);
        return 24'((n * 32'h0001_C3D7) ^ 32'h000F_0F0F);
    endfunction
    function automatic logic [31:0] cs_word(int s, int w);
        return 32'(32'h9E37_79B9 * (w + 1 + s * 7)) ^ (s != 0 ? 32'h5555_AAAA : 32'h0);
    endfunction

    always @(posedge clk) fire_q <= s_valid & s_ready;

    always @(negedge clk) begin
        if (drv_clr) k = 0;
        else if (fire_q) k = k + 1;
        s_a = smp_a(k);
        s_b = smp_b(k);
        s_v = k[2];
        s_u = k[0];
        s_c = k[1];
    end

    always @(negedge clk) begin
        if (rec_clr) rec_n = 0;
        else if (rec_on && rec_n < 32768) begin
            rec[rec_n] = line_out;
            rec_n = rec_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bring-up order: both resets low, output reset released, input reset released, enable
    task automatic start_phase(input int ph);
        cur_ph    = ph;
        enable    = 1'b0;
        rst_out_n = 1'b0;
        rst_in_n  = 1'b0;
        drv_clr   = 1'b1;
        cyc(4);
        drv_clr   = 1'b0;
        rst_out_n = 1'b1;
        cyc(2);
        rst_in_n  = 1'b1;
        cyc(4);
        if (ph == 3) begin
            rst_in_n = 1'b0;
            cyc(2);
        end
        rec_clr = 1'b1;
        cyc(1);
        rec_clr = 1'b0;
        rec_on  = 1'b1;
        enable  = 1'b1;
    endtask

    // Expected slots 4..31 (bit 0 = slot 4) of frame f, channel c
    function automatic logic [27:0] exp_sf(int f, int c);
        logic [27:0] r;
        logic [23:0] aud;
        bit miss;
        int n;
        logic sv, su, sc, vb, ub, cb;
        miss = (f == 0) || (cur_ph == 3);
        n    = f - 1;
        aud  = miss ? 24'h0 : (c != 0 ? smp_b(n) : smp_a(n));
        sv   = miss ? 1'b0 : n[2];
        su   = miss ? 1'b0 : n[0];
        sc   = miss ? 1'b0 : n[1];
        for (int i = 0; i < 24; i++) r[i] = msb_first ? aud[23 - i] : aud[i];
        vb = miss ? 1'b1 : (v_sel ? sv : v_set);
        ub = u_sel ? su : u_set;
        cb = c_sel ? sc : cs_word(c, (f % 192) / 32)[(f % 192) % 32];
        r[24] = vb;
        r[25] = ub;
        r[26] = cb;
        r[27] = ^r[26:0];
        return r;
    endfunction

    task automatic decode(input int nfr);
        int p;
        p = -1;
        for (int i = 0; i < 400; i++) begin
            if (p < 0 && rec[i] == 1'b1) p = i;
        end
        chk(p > 0, "R4 first frame found", 32'(p), 32'd1);
        if (p <= 0) return;
        for (int f = 0; f < nfr; f++) begin
            for (int c = 0; c < 2; c++) begin
                int base;
                logic prev;
                logic [7:0] got, want;
                logic [27:0] bits, ex;
                bit edges_ok;
                base = p + f * 128 + c * 64;
                prev = rec[base - 1];
                for (int j = 0; j < 8; j++) got[7 - j] = rec[base + j];
                want = (c == 1) ? 8'b1110_0100 : ((f % 192 == 0) ? 8'b1110_1000 : 8'b1110_0010);
                want = want ^ {8{prev}};
                chk(got == want, (f % 192 == 0 && c == 0) ? "R4 block start B" : "R3 preamble",
                    32'(got), 32'(want));
                edges_ok = 1;
                for (int s = 4; s < 32; s++) begin
                    int h;
                    h = base + 2 * s;
                    if (rec[h] == rec[h - 1]) edges_ok = 0;
                    bits[s - 4] = rec[h] ^ rec[h + 1];
                end
                chk(edges_ok, "R2 cell boundary transitions", 32'(edges_ok), 32'd1);
                ex = exp_sf(f, c);
                chk(bits[23:0] == ex[23:0], (f == 0 || cur_ph == 3) ? "R11 silent audio" : "R5 audio",
                    32'(bits[23:0]), 32'(ex[23:0]));
                chk(bits[24] == ex[24], (f == 0 || cur_ph == 3) ? "R11 forced V" : "R6 V bit",
                    32'(bits[24]), 32'(ex[24]));
                chk(bits[25] == ex[25], "R7 U bit", 32'(bits[25]), 32'(ex[25]));
                chk(bits[26] == ex[26], "R8 C bit", 32'(bits[26]), 32'(ex[26]));
                chk(^bits == 1'b0, "R9 even parity", 32'(bits), 32'(ex));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        int hold_bad;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        chk(line_out == 1'b0, "R1 idle line after reset", 32'(line_out), 32'd0);
        chk(s_ready == 1'b1, "R10 ready after reset", 32'(s_ready), 32'd1);

        // R13: load both channel-status banks
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 6; w++) begin
                cs_we    = 1'b1;
                cs_side  = s[0];
                cs_idx   = 3'(w);
                cs_wdata = cs_word(s, w);
                cyc(1);
            end
        end
        cs_we   = 1'b0;
        s_valid = 1'b1;

        // Phase 0: manual V=0, U=1, C from banks, LSB first, across a block wrap
        msb_first = 0; v_sel = 0; v_set = 0; u_sel = 0; u_set = 1; c_sel = 0;
        start_phase(0);
        cyc(10);
        chk(s_ready == 1'b0, "R10 pending pair blocks ready", 32'(s_ready), 32'd0);
        cyc(200 * 128);
        rec_on = 1'b0;
        enable = 1'b0;
        decode(198);
        cyc(2);
        hold_bad = 0;
        for (int i = 0; i < 300; i++) begin
            if (line_out !== 1'b0) hold_bad++;
            cyc(1);
        end
        chk(hold_bad == 0, "R1 line quiet after enable cleared", 32'(hold_bad), 32'd0);

        // Phase 1: mute, stream U and C, MSB first
        msb_first = 1; v_sel = 0; v_set = 1; u_sel = 1; u_set = 0; c_sel = 1;
        start_phase(1);
        cyc(12 * 128);
        rec_on = 1'b0;
        decode(10);
        rst_out_n = 1'b0;
        cyc(3);
        chk(line_out == 1'b0, "R1 output reset silences line", 32'(line_out), 32'd0);

        // Phase 2: stream V, manual U=0, banks for C
        msb_first = 0; v_sel = 1; v_set = 0; u_sel = 0; u_set = 0; c_sel = 0;
        start_phase(2);
        cyc(12 * 128);
        rec_on = 1'b0;
        enable = 1'b0;
        decode(10);

        // Phase 3: input path held in reset after a pair was preloaded
        msb_first = 0; v_sel = 0; v_set = 0; u_sel = 0; u_set = 1; c_sel = 0;
        start_phase(3);
        cyc(5);
        chk(s_ready == 1'b0, "R12 ready low in input reset", 32'(s_ready), 32'd0);
        cyc(6 * 128);
        rec_on = 1'b0;
        enable = 1'b0;
        decode(4);

        done = 1;
        summary();
    end
endmodule